// File: doc/BRIEF.md
# Standard Event Status Register

This block keeps the eight-bit event status byte of an instrument's remote-control status system, together with the eight-bit enable mask that chooses which latched events reach the status byte. Other parts of the instrument raise one-cycle pulses when an operation completes, when a query, device-dependent, execution or command error happens, and when the power-up self-test passes. Each pulse latches its own bit. The bit stays latched until software reads the register or issues a clear-all command.

A read strobe takes the current contents, which are always visible on the value output, and empties the register at the next clock edge. The enable mask can be written and read back. At power-up the mask is either zeroed or restored from a saved copy, and a stored power-on-clear flag decides which. The summary output feeds the status byte. It is true while any latched event is also enabled. Reset is asserted asynchronously and released through an internal two-stage synchronizer.

Top module: `std_event_status`

## Requirements
- R1: While reset is held and for the first two rising edges after rst_n goes high, the event value, the mask value and the summary all read 0.
- R2: A pulse on an event input sets its bit one clock later. The bit positions are: bit 0 operation done, bit 2 query error, bit 3 device error, bit 4 execution error, bit 5 command error, bit 7 power-on.
- R3: Bits 1 and 6 of the event value always read 0.
- R4: A set event bit stays set until a read strobe or a clear-all strobe is applied.
- R5: The event value output shows the register contents. A read strobe clears every bit at the next clock edge.
- R6: An event pulse in the same cycle as a read or clear-all strobe leaves that event's bit set after the edge, and the read still returns the old value.
- R7: Clear-all empties the event register and leaves the mask unchanged.
- R8: A mask write takes effect on the next clock edge, and the mask value output returns the stored mask.
- R9: The summary is 1 exactly when the event value AND the mask value has any bit set. It follows the registered values in the same cycle.
- R10: On the first clock edge after reset is released internally, the mask loads 0 if pon_clear_flag is 1, or loads saved_mask if the flag is 0. A mask write in that cycle is ignored.
- R11: The power-on bit is set by the first selftest_pass pulse after reset. Later pulses have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_op_done | input | 1 | Operation-complete pulse |
| ev_query_err | input | 1 | Query-error pulse |
| ev_dev_err | input | 1 | Device-dependent error pulse |
| ev_exec_err | input | 1 | Execution-error pulse |
| ev_cmd_err | input | 1 | Command-error pulse |
| selftest_pass | input | 1 | Power-up self-test passed pulse |
| evt_read | input | 1 | Destructive read strobe |
| clear_all | input | 1 | Clear-all strobe |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | Mask write data |
| pon_clear_flag | input | 1 | Stored power-on-clear flag |
| saved_mask | input | 8 | Saved mask restored at power-up |
| evt_value | output | 8 | Event register contents |
| mask_value | output | 8 | Enable mask contents |
| summary | output | 1 | Summary bit for the status byte |

## Verification
The bench puts an event pulse in the same cycle as a read or a clear-all. A design that gives the clear priority would lose that event, and the bench would see it missing. It sends repeated self-test pulses, which a design without a one-shot arm would latch again after every read. It also runs boot in both flag settings. If the mask were not restored, or were restored from the wrong source, the summary would drift away from the enabled events. Finally, it checks that a clear-all leaves the mask alone and that bits 1 and 6 stay 0 under random traffic.

// File: rtl/evs_pkg.sv
package evs_pkg;
  localparam int EVS_W = 8;
  localparam int B_OPDONE = 0;
  localparam int B_QUERY  = 2;
  localparam int B_DEVICE = 3;
  localparam int B_EXEC   = 4;
  localparam int B_CMD    = 5;
  localparam int B_PWRON  = 7;
  localparam logic [EVS_W-1:0] EVS_LIVE =
    EVS_W'((1 << B_OPDONE) | (1 << B_QUERY) | (1 << B_DEVICE) |
           (1 << B_EXEC) | (1 << B_CMD) | (1 << B_PWRON));
endpackage

// File: rtl/evs_rst_sync.sv
module evs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/evs_pon_gate.sv
module evs_pon_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic pass_pulse,
  output logic pon_set
);
  logic armed_q;
  logic armed_d;
  logic armed_en;

  always_comb begin
    armed_en = armed_q & pass_pulse;
    armed_d  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b1;
    else if (armed_en) armed_q <= armed_d;
  end

  assign pon_set = pass_pulse & armed_q;

  p_disarmed_stays_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> !armed_q);
  p_fire_disarms_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pon_set |=> (!armed_q && !pon_set));
endmodule

// File: rtl/evs_event_reg.sv
module evs_event_reg import evs_pkg::*; #(
  parameter int              W    = EVS_W,
  parameter logic [W-1:0]    LIVE = EVS_LIVE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         rd_stb,
  input  logic         clr_stb,
  output logic [W-1:0] evt_q
);
  logic         flush;
  logic [W-1:0] set_live;
  logic [W-1:0] evt_d;
  logic [W-1:0] bit_en;

  always_comb begin
    flush    = rd_stb | clr_stb;
    set_live = set_vec & LIVE;
    evt_d    = (flush ? '0 : evt_q) | set_live;
    bit_en   = {W{flush}} | set_live;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (LIVE[i]) begin : g_live
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         q <= 1'b0;
        else if (bit_en[i]) q <= evt_d[i];
      end
      assign evt_q[i] = q;
    end else begin : g_dead
      assign evt_q[i] = 1'b0;
    end
  end

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> ((evt_q & $past(evt_q)) == $past(evt_q)));
  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_live) |=> ((evt_q & $past(set_live)) == $past(set_live)));
  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !(|set_live)) |=> (evt_q == '0));
  p_new_survives_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (evt_q == $past(set_live)));
endmodule

// File: rtl/evs_mask_reg.sv
module evs_mask_reg import evs_pkg::*; #(
  parameter int W = EVS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_data,
  input  logic         pon_clear,
  input  logic [W-1:0] saved,
  output logic [W-1:0] msk_q
);
  logic         boot_q;
  logic [W-1:0] msk_d;
  logic         msk_en;

  always_comb begin
    msk_en = boot_q | wr_stb;
    if (boot_q) msk_d = pon_clear ? '0 : saved;
    else        msk_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boot_q <= 1'b1;
    else        boot_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      msk_q <= '0;
    else if (msk_en) msk_q <= msk_d;
  end

  p_boot_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    boot_q |=> (msk_q == ($past(pon_clear) ? '0 : $past(saved))));
  p_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !boot_q) |=> (msk_q == $past(wr_data)));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && !boot_q) |=> $stable(msk_q));
endmodule

// File: rtl/std_event_status.sv
module std_event_status import evs_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_op_done,
  input  logic             ev_query_err,
  input  logic             ev_dev_err,
  input  logic             ev_exec_err,
  input  logic             ev_cmd_err,
  input  logic             selftest_pass,
  input  logic             evt_read,
  input  logic             clear_all,
  input  logic             mask_wr,
  input  logic [EVS_W-1:0] mask_wdata,
  input  logic             pon_clear_flag,
  input  logic [EVS_W-1:0] saved_mask,
  output logic [EVS_W-1:0] evt_value,
  output logic [EVS_W-1:0] mask_value,
  output logic             summary
);
  logic             rst_int_n;
  logic             pon_set;
  logic [EVS_W-1:0] set_vec;

  evs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n));

  evs_pon_gate u_pon (
    .clk(clk), .rst_n(rst_int_n), .pass_pulse(selftest_pass), .pon_set(pon_set));

  always_comb begin
    set_vec           = '0;
    set_vec[B_OPDONE] = ev_op_done;
    set_vec[B_QUERY]  = ev_query_err;
    set_vec[B_DEVICE] = ev_dev_err;
    set_vec[B_EXEC]   = ev_exec_err;
    set_vec[B_CMD]    = ev_cmd_err;
    set_vec[B_PWRON]  = pon_set;
  end

  evs_event_reg #(.W(EVS_W), .LIVE(EVS_LIVE)) u_evt (
    .clk(clk), .rst_n(rst_int_n), .set_vec(set_vec),
    .rd_stb(evt_read), .clr_stb(clear_all), .evt_q(evt_value));

  evs_mask_reg #(.W(EVS_W)) u_msk (
    .clk(clk), .rst_n(rst_int_n), .wr_stb(mask_wr), .wr_data(mask_wdata),
    .pon_clear(pon_clear_flag), .saved(saved_mask), .msk_q(mask_value));

  assign summary = |(evt_value & mask_value);

  p_clear_keeps_mask_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (clear_all && !mask_wr) |=> (evt_value == '0 || $past(|set_vec)) && $stable(mask_value));
endmodule

// File: tb/sim_std_event_status.sv
module sim_std_event_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_op_done = 0, ev_query_err = 0, ev_dev_err = 0, ev_exec_err = 0, ev_cmd_err = 0;
  logic selftest_pass = 0, evt_read = 0, clear_all = 0, mask_wr = 0;
  logic [7:0] mask_wdata = 8'h00;
  logic pon_clear_flag = 1'b0;
  logic [7:0] saved_mask = 8'hA5;
  logic [7:0] evt_value, mask_value;
  logic summary;

  int total = 0, bad = 0;
  string cur_req = "R1";
  int m_evt, m_msk, m_cnt;
  bit m_boot, m_armed, finished = 0;

  always #5 clk = ~clk;

  std_event_status u0 (
    .clk(clk), .rst_n(rst_n), .ev_op_done(ev_op_done), .ev_query_err(ev_query_err),
    .ev_dev_err(ev_dev_err), .ev_exec_err(ev_exec_err), .ev_cmd_err(ev_cmd_err),
    .selftest_pass(selftest_pass), .evt_read(evt_read), .clear_all(clear_all),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .pon_clear_flag(pon_clear_flag),
    .saved_mask(saved_mask), .evt_value(evt_value), .mask_value(mask_value),
    .summary(summary));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int setv;
    if (!rst_n) begin
      m_cnt = 0; m_evt = 0; m_msk = 0; m_boot = 1; m_armed = 1;
    end else if (m_cnt < 2) begin
      m_cnt++;
    end else begin
      setv = (ev_op_done << 0) | (ev_query_err << 2) | (ev_dev_err << 3) |
             (ev_exec_err << 4) | (ev_cmd_err << 5) |
             ((selftest_pass && m_armed) << 7);
      if (selftest_pass) m_armed = 0;
      if (evt_read || clear_all) m_evt = 0;
      m_evt = m_evt | setv;
      if (m_boot) begin
        m_msk = pon_clear_flag ? 0 : saved_mask;
        m_boot = 0;
      end else if (mask_wr) m_msk = mask_wdata;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
    chk({cur_req, " evt"}, evt_value, m_evt);
    chk({cur_req, " mask"}, mask_value, m_msk);
    chk({cur_req, " summary"}, summary, ((m_evt & m_msk) != 0));
    @(negedge clk);
    ev_op_done = 0; ev_query_err = 0; ev_dev_err = 0; ev_exec_err = 0; ev_cmd_err = 0;
    selftest_pass = 0; evt_read = 0; clear_all = 0; mask_wr = 0;
  endtask

  task automatic do_reset(input bit flag, input logic [7:0] sv);
    @(negedge clk);
    rst_n = 0; pon_clear_flag = flag; saved_mask = sv;
    tick();
    rst_n = 1;
    cur_req = "R1";
    tick(); chk("R1 hold evt", evt_value, 0); chk("R1 hold mask", mask_value, 0);
    tick(); chk("R1 hold summary", summary, 0);
    cur_req = "R10";
    tick();
  endtask

  initial begin
    #(10 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    do_reset(1'b0, 8'hA5);
    chk("R10 restored mask", mask_value, 8'hA5);

    cur_req = "R11";
    selftest_pass = 1; tick();
    chk("R11 pwron bit", evt_value, 8'h80);
    chk("R9 summary pwron enabled", summary, 1);
    evt_read = 1; tick();
    chk("R5 read cleared", evt_value, 0);
    selftest_pass = 1; tick();
    chk("R11 second pass ignored", evt_value, 0);

    cur_req = "R2";
    ev_op_done = 1;   tick(); chk("R2 bit0", evt_value, 8'h01); evt_read = 1; tick();
    ev_query_err = 1; tick(); chk("R2 bit2", evt_value, 8'h04); evt_read = 1; tick();
    ev_dev_err = 1;   tick(); chk("R2 bit3", evt_value, 8'h08); evt_read = 1; tick();
    ev_exec_err = 1;  tick(); chk("R2 bit4", evt_value, 8'h10); evt_read = 1; tick();
    ev_cmd_err = 1;   tick(); chk("R2 bit5", evt_value, 8'h20); evt_read = 1; tick();

    cur_req = "R8";
    mask_wr = 1; mask_wdata = 8'hFF;
    chk("R8 not yet written", mask_value, 8'hA5);
    tick(); chk("R8 mask written", mask_value, 8'hFF);

    cur_req = "R3";
    ev_op_done = 1; ev_query_err = 1; ev_dev_err = 1; ev_exec_err = 1; ev_cmd_err = 1;
    tick(); chk("R3 dead bits zero", evt_value & 8'h42, 0);
    chk("R3 all live", evt_value, 8'h3D);

    cur_req = "R4";
    repeat (5) tick();
    chk("R4 sticky", evt_value, 8'h3D);

    cur_req = "R6";
    evt_read = 1; ev_exec_err = 1;
    chk("R6 read returns old", evt_value, 8'h3D);
    tick(); chk("R6 new event kept on read", evt_value, 8'h10);
    clear_all = 1; ev_cmd_err = 1;
    tick(); chk("R6 new event kept on clear", evt_value, 8'h20);

    cur_req = "R7";
    clear_all = 1; tick();
    chk("R7 cleared", evt_value, 0);
    chk("R7 mask kept", mask_value, 8'hFF);

    cur_req = "R9";
    mask_wr = 1; mask_wdata = 8'h20; ev_cmd_err = 1; tick();
    chk("R9 summary on", summary, 1);
    mask_wr = 1; mask_wdata = 8'h01; tick();
    chk("R9 summary off", summary, 0);

    do_reset(1'b1, 8'hFF);
    chk("R10 cleared mask", mask_value, 0);
    cur_req = "R11";
    selftest_pass = 1; tick(); chk("R11 after new reset", evt_value, 8'h80);
    chk("R9 masked off", summary, 0);

    cur_req = "R5";
    lf = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      ev_op_done = lf[0]; ev_query_err = lf[1] & lf[7]; ev_dev_err = lf[2] & lf[8];
      ev_exec_err = lf[3] & lf[9]; ev_cmd_err = lf[4] & lf[10];
      selftest_pass = lf[5] & lf[11];
      evt_read = lf[6] & lf[12] & lf[13]; clear_all = lf[14] & lf[15] & lf[1];
      mask_wr = lf[11] & lf[2]; mask_wdata = lf[15:8];
      tick();
      chk("R3 random dead bits", evt_value & 8'h42, 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule